// File: doc/BRIEF.md
# Dual-Address DMA Transfer Sequencer

This block is the engine of one DMA channel. It moves a block of bytes from a source region to a destination region. Each transfer is a read phase on the source followed by a write phase on the destination. Software loads the source address, destination address, byte count and control word through a register load port. A request input then starts the block. The sequencer runs the bus cycles on a simple single-master bus, where every cycle ends on a ready strobe that may carry an error flag. It moves the addresses and the count as the cycles complete, and it reports progress on a four-bit status output.

When the destination access is wider than the source access, several narrow reads fill one write, packed from the lowest byte lane upward. A bandwidth-control code can make the channel give up its bus request for one cycle whenever the remaining count lands on a power-of-two boundary. This gives other masters a slot. Arbitration between channels and the pin-level request logic sit outside the block.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset, chan_stat is 0 and bus_valid and bus_req are both low.
- R2: In idle, a high xfer_req is accepted only when the byte count is nonzero and both size codes are valid with source size not larger than destination size. Accepting it sets chan_stat[0] (request seen) and chan_stat[1] (busy), and the first read is on the bus in the next cycle. Any other request is ignored, and chan_stat and the bus stay idle.
- R3: In a read cycle, bus_addr is the source address, bus_wr is 0 and bus_size is the source size code. Address and direction hold until bus_ready. After a read ends without error, the source address grows by the source size when control bit 0 is set.
- R4: Size codes are 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes, and 11 is invalid. The channel performs destination/source reads per transfer. Read k places its bytes at lanes k*source size and up (lane 0 = bus_wdata[7:0]), and the write drives those lanes with the unused upper lanes zero.
- R5: In a write cycle, bus_addr is the destination address, bus_wr is 1 and bus_size is the destination size code. After a write ends without error, the destination address grows by the destination size when control bit 1 is set.
- R6: After each good write, the count drops by the destination size (floored at zero). At zero, chan_stat[2] (done) sets and busy clears. Otherwise the next read starts, and busy and done are never high together.
- R7: bus_req is high exactly while a bus cycle is active. If, after a good write, the remaining count is nonzero and a multiple of 2^(code+1) for a nonzero bandwidth code (control bits 8:6), the channel spends one cycle with bus_req low before the next read. Code 000 never releases.
- R8: A cycle that ends with bus_err sets chan_stat[3] (bus error) and done, clears busy, and no further bus cycle is issued.
- R9: While done is set, requests are ignored. A register write to select 4 with data bit 2 set clears done, bus error and request seen, and leaves the channel idle.
- R10: Register writes (select 0 source, 1 destination, 2 count, 3 control) take effect at once, even mid-block. A write wins over an update from the bus in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 source, 1 destination, 2 count, 3 control, 4 status |
| cfg_wdata | input | CFG_W | Register write data |
| xfer_req | input | 1 | Transfer request |
| bus_req | output | 1 | Bus request toward the arbiter |
| bus_valid | output | 1 | Bus cycle active |
| bus_wr | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | ADDR_W | Byte address of the cycle |
| bus_size | output | 2 | Access size code of the cycle |
| bus_wdata | output | DATA_W | Write data, packed from lane 0 |
| bus_rdata | input | DATA_W | Read data, right-justified |
| bus_ready | input | 1 | Cycle termination strobe |
| bus_err | input | 1 | Error flag, valid with bus_ready |
| chan_stat | output | 4 | {bus error, done, busy, request seen} |

## Verification
The bench builds the block with a 16-bit count and the release base of 1. The smallest nonzero bandwidth code therefore releases the bus every 4 bytes, and a release cycle shows up inside an 8-byte block. The 32-bit data path makes all three packing ratios (1:1, 1:2 via halfwords, 1:4 via bytes) reachable. The slave in the bench adds wait states and injects errors on a chosen cycle of a read or write phase.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WRITE,
      ST_RELEASE,
      ST_DONE
   } seq_state_e;

   localparam logic [2:0] SEL_SRC  = 3'd0;
   localparam logic [2:0] SEL_DST  = 3'd1;
   localparam logic [2:0] SEL_CNT  = 3'd2;
   localparam logic [2:0] SEL_CTRL = 3'd3;
   localparam logic [2:0] SEL_STAT = 3'd4;

   localparam int STAT_CLR_BIT = 2;

   // byte count of a size code, 0 for the invalid code
   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (code)
         2'b00:   size_bytes = 3'd1;
         2'b01:   size_bytes = 3'd2;
         2'b10:   size_bytes = 3'd4;
         default: size_bytes = 3'd0;
      endcase
   endfunction

   function automatic logic [1:0] size_log2(input logic [1:0] code);
      case (code)
         2'b01:   size_log2 = 2'd1;
         2'b10:   size_log2 = 2'd2;
         default: size_log2 = 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/dma_seq_addr.sv
module dma_seq_addr #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [ADDR_W-1:0] ld_val,
   input  logic              adv,
   input  logic [2:0]        adv_bytes,
   output logic [ADDR_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (ld) begin
         q <= ld_val;
      end else if (adv) begin
         q <= q + ADDR_W'(adv_bytes);
      end
   end

endmodule

// File: rtl/dma_seq_pack.sv
module dma_seq_pack #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [$clog2(DATA_W/8)-1:0] lane_off,
   input  logic [$clog2(DATA_W/8):0]   src_nb,
   input  logic [$clog2(DATA_W/8):0]   dst_nb,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] wdata
);

   localparam int NB    = DATA_W / 8;
   localparam int OFF_W = $clog2(NB);

   for (genvar i = 0; i < NB; i++) begin : g_lane
      localparam logic [OFF_W:0] IDX = (OFF_W+1)'(i);
      logic [OFF_W:0]    rel;
      logic              in_win;
      logic [DATA_W-1:0] shifted;
      logic [7:0]        lane_q;

      always_comb begin
         rel     = IDX - {1'b0, lane_off};
         in_win  = (IDX >= {1'b0, lane_off}) && (rel < src_nb);
         shifted = rdata >> {rel[OFF_W-1:0], 3'b000};
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q <= '0;
         end else if (cap && in_win) begin
            lane_q <= shifted[7:0];
         end
      end

      assign wdata[i*8 +: 8] = (IDX < dst_nb) ? lane_q : 8'h00;
   end

endmodule

// File: rtl/dma_seq_bwgate.sv
module dma_seq_bwgate #(
   parameter int CNT_W     = 24,
   parameter int BWC_W     = 3,
   parameter int BW_BASE   = 1,
   parameter bit BW_ENABLE = 1'b1
) (
   input  logic [CNT_W-1:0] cnt_next,
   input  logic [BWC_W-1:0] code,
   output logic             hit
);

   if (BW_ENABLE) begin : g_on
      logic [7:0]       sh;
      logic [CNT_W-1:0] mask;
      always_comb begin
         sh   = 8'(code) + 8'(BW_BASE);
         mask = ~({CNT_W{1'b1}} << sh);
         hit  = (code != '0) && (cnt_next != '0) && ((cnt_next & mask) == '0);
      end
   end else begin : g_off
      logic unused_in;
      assign unused_in = ^{cnt_next, code};
      assign hit = 1'b0;
   end

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 24,
   parameter int BWC_W     = 3,
   parameter int BW_BASE   = 1,
   parameter bit BW_ENABLE = 1'b1,
   parameter int CFG_W     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              xfer_req,
   output logic              bus_req,
   output logic              bus_valid,
   output logic              bus_wr,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [1:0]        bus_size,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ready,
   input  logic              bus_err,
   output logic [3:0]        chan_stat
);

   localparam int NB     = DATA_W / 8;
   localparam int OFF_W  = $clog2(NB);
   localparam int CTRL_W = 6 + BWC_W;

   if (DATA_W != 32) begin : g_bad_data
      $error("dma_xfer_seq: DATA_W must be 32 to carry 4-byte accesses");
   end
   if (CFG_W < ADDR_W || CFG_W < CNT_W || CFG_W < CTRL_W) begin : g_bad_cfg
      $error("dma_xfer_seq: CFG_W narrower than a loadable register");
   end
   if (BW_BASE + (1 << BWC_W) - 1 >= CNT_W) begin : g_bad_bw
      $error("dma_xfer_seq: largest release boundary exceeds the count width");
   end

   seq_state_e        state_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [OFF_W-1:0]  beat_q;
   logic              reqst_q, done_q, err_q;

   logic              sinc, dinc;
   logic [1:0]        ssz, dsz;
   logic [BWC_W-1:0]  bwc;
   logic [2:0]        sb, db;
   logic [1:0]        src_lg;
   logic              cfg_ok, st_clr;
   logic              rd_term, wr_term, rd_ok, wr_ok;
   logic [OFF_W+1:0]  fill;
   logic              last_beat;
   logic [OFF_W-1:0]  lane_off;
   logic [CNT_W-1:0]  cnt_nxt;
   logic              bw_hit, busy;
   logic [ADDR_W-1:0] sar, dar;

   assign sinc   = ctrl_q[0];
   assign dinc   = ctrl_q[1];
   assign ssz    = ctrl_q[3:2];
   assign dsz    = ctrl_q[5:4];
   assign bwc    = ctrl_q[6 +: BWC_W];
   assign sb     = size_bytes(ssz);
   assign db     = size_bytes(dsz);
   assign src_lg = size_log2(ssz);

   assign cfg_ok = (sb != 3'd0) && (db != 3'd0) && (sb <= db) && (cnt_q != '0);
   assign st_clr = cfg_we && (cfg_sel == SEL_STAT) && cfg_wdata[STAT_CLR_BIT];

   assign rd_term = (state_q == ST_READ) && bus_ready;
   assign wr_term = (state_q == ST_WRITE) && bus_ready;
   assign rd_ok   = rd_term && !bus_err && !st_clr;
   assign wr_ok   = wr_term && !bus_err && !st_clr;

   always_comb begin
      fill      = ({2'b00, beat_q} + 1'b1) << src_lg;
      last_beat = fill >= {{(OFF_W-1){1'b0}}, db};
      lane_off  = beat_q << src_lg;
      cnt_nxt   = (cnt_q > CNT_W'(db)) ? cnt_q - CNT_W'(db) : '0;
   end

   // address registers: register load beats bus-driven advance
   dma_seq_addr #(.ADDR_W(ADDR_W)) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld        (cfg_we && cfg_sel == SEL_SRC),
      .ld_val    (cfg_wdata[ADDR_W-1:0]),
      .adv       (rd_ok && sinc),
      .adv_bytes (sb),
      .q         (sar)
   );

   dma_seq_addr #(.ADDR_W(ADDR_W)) u_dst (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld        (cfg_we && cfg_sel == SEL_DST),
      .ld_val    (cfg_wdata[ADDR_W-1:0]),
      .adv       (wr_ok && dinc),
      .adv_bytes (db),
      .q         (dar)
   );

   dma_seq_pack #(.DATA_W(DATA_W)) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap      (rd_ok),
      .lane_off (lane_off),
      .src_nb   ((OFF_W+1)'(sb)),
      .dst_nb   ((OFF_W+1)'(db)),
      .rdata    (bus_rdata),
      .wdata    (bus_wdata)
   );

   dma_seq_bwgate #(
      .CNT_W     (CNT_W),
      .BWC_W     (BWC_W),
      .BW_BASE   (BW_BASE),
      .BW_ENABLE (BW_ENABLE)
   ) u_bw (
      .cnt_next (cnt_nxt),
      .code     (bwc),
      .hit      (bw_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (cfg_we && cfg_sel == SEL_CTRL) begin
            ctrl_q <= cfg_wdata[CTRL_W-1:0];
         end
         if (cfg_we && cfg_sel == SEL_CNT) begin
            cnt_q <= cfg_wdata[CNT_W-1:0];
         end else if (wr_ok) begin
            cnt_q <= cnt_nxt;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         beat_q  <= '0;
         reqst_q <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else if (st_clr) begin
         state_q <= ST_IDLE;
         beat_q  <= '0;
         reqst_q <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (xfer_req && cfg_ok) begin
                  state_q <= ST_READ;
                  reqst_q <= 1'b1;
                  beat_q  <= '0;
               end
            end
            ST_READ: begin
               if (rd_term) begin
                  if (bus_err) begin
                     done_q  <= 1'b1;
                     err_q   <= 1'b1;
                     state_q <= ST_DONE;
                  end else if (last_beat) begin
                     beat_q  <= '0;
                     state_q <= ST_WRITE;
                  end else begin
                     beat_q  <= beat_q + 1'b1;
                  end
               end
            end
            ST_WRITE: begin
               if (wr_term) begin
                  if (bus_err) begin
                     done_q  <= 1'b1;
                     err_q   <= 1'b1;
                     state_q <= ST_DONE;
                  end else if (cnt_nxt == '0) begin
                     done_q  <= 1'b1;
                     state_q <= ST_DONE;
                  end else if (bw_hit) begin
                     state_q <= ST_RELEASE;
                  end else begin
                     state_q <= ST_READ;
                  end
               end
            end
            ST_RELEASE: state_q <= ST_READ;
            ST_DONE:    state_q <= ST_DONE;
            default:    state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state_q == ST_READ) || (state_q == ST_WRITE) || (state_q == ST_RELEASE);
   assign bus_valid = (state_q == ST_READ) || (state_q == ST_WRITE);
   assign bus_req   = bus_valid;
   assign bus_wr    = (state_q == ST_WRITE);
   assign bus_addr  = bus_wr ? dar : sar;
   assign bus_size  = bus_wr ? dsz : ssz;
   assign chan_stat = {err_q, done_q, busy, reqst_q};

endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic              st_clr,
   input logic              bus_req,
   input logic              bus_valid,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_ready,
   input logic              bus_err,
   input logic [3:0]        chan_stat
);

   // R3: a pending cycle keeps address and direction until it ends
   p_hold_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_ready && !cfg_we |=> bus_valid && $stable(bus_addr) && $stable(bus_wr));

   // R6: busy and done never together
   p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(chan_stat[1] && chan_stat[2]));

   // R7: a bus cycle always runs under a request
   p_req_covers_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> bus_req);

   // R8: an error ending sets error and done and stops the bus
   p_err_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_ready && bus_err && !cfg_we |=> chan_stat[3] && chan_stat[2] && !bus_valid);

   // R8: once done, the channel stays off the bus
   p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      chan_stat[2] |-> !bus_valid && !bus_req);

   // R9: a bus error flag is never seen without done
   p_err_has_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      chan_stat[3] |-> chan_stat[2]);

   // R9: the clear write returns all status to zero
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      st_clr |=> chan_stat == 4'b0000);

endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .st_clr    (st_clr),
   .bus_req   (bus_req),
   .bus_valid (bus_valid),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_ready (bus_ready),
   .bus_err   (bus_err),
   .chan_stat (chan_stat)
);

// File: tb/dma_xfer_seq_bench.sv
module dma_xfer_seq_bench;

   localparam int AW = 32;
   localparam int DW = 32;
   localparam int CW = 16;

   logic          clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n;
   logic          cfg_we;
   logic [2:0]    cfg_sel;
   logic [31:0]   cfg_wdata;
   logic          xfer_req;
   logic          bus_req, bus_valid, bus_wr;
   logic [AW-1:0] bus_addr;
   logic [1:0]    bus_size;
   logic [DW-1:0] bus_wdata;
   logic [DW-1:0] bus_rdata;
   logic          bus_ready, bus_err;
   logic [3:0]    chan_stat;

   dma_xfer_seq #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .BWC_W(3), .BW_BASE(1),
                  .BW_ENABLE(1'b1), .CFG_W(32)) u_dma_xfer_seq (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .xfer_req(xfer_req), .bus_req(bus_req), .bus_valid(bus_valid), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ready(bus_ready), .bus_err(bus_err), .chan_stat(chan_stat)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   logic [7:0] mem [0:4095];

   // reference model state
   int         m_ph;     // 0 idle, 1 read, 2 write, 3 release, 4 done
   logic [31:0] m_sar, m_dar;
   int         m_cnt;
   logic [8:0] m_ctrl;
   logic [7:0] m_buf [4];
   int         m_beat;
   bit         m_reqst, m_done, m_err;

   // slave state
   int s_wait, s_wcnt, s_idx, s_err_at;
   int rel_seen;

   function automatic int sz(input logic [1:0] c);
      case (c)
         2'b00: return 1;
         2'b01: return 2;
         2'b10: return 4;
         default: return 0;
      endcase
   endfunction

   function automatic logic [3:0] exp_stat();
      return {m_err, m_done, (m_ph == 1 || m_ph == 2 || m_ph == 3), m_reqst};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   task automatic slave_drive();
      bus_ready = 1'b0;
      bus_err   = 1'b0;
      bus_rdata = '0;
      if (m_ph == 1 || m_ph == 2) begin
         if (s_wcnt >= s_wait) begin
            bus_ready = 1'b1;
            bus_err   = (s_idx == s_err_at);
            s_wcnt    = 0;
            s_idx++;
         end else begin
            s_wcnt++;
         end
         if (m_ph == 1) begin
            for (int k = 0; k < sz(m_ctrl[3:2]); k++)
               bus_rdata[k*8 +: 8] = mem[12'(m_sar + 32'(k))];
         end
      end
   endtask

   task automatic model_step();
      int sb, db, bwc;
      bit clr;
      sb  = sz(m_ctrl[3:2]);
      db  = sz(m_ctrl[5:4]);
      bwc = int'(m_ctrl[8:6]);
      clr = cfg_we && cfg_sel == 3'd4 && cfg_wdata[2];
      if (clr) begin
         m_ph = 0; m_reqst = 0; m_done = 0; m_err = 0;
      end else begin
         case (m_ph)
            0: if (xfer_req && sb != 0 && db != 0 && sb <= db && m_cnt != 0) begin
                  m_ph = 1; m_reqst = 1; m_beat = 0;
               end
            1: if (bus_ready) begin
                  if (bus_err) begin
                     m_done = 1; m_err = 1; m_ph = 4;
                  end else begin
                     for (int k = 0; k < sb; k++) m_buf[m_beat*sb + k] = bus_rdata[k*8 +: 8];
                     if (m_ctrl[0]) m_sar = m_sar + 32'(sb);
                     if ((m_beat + 1) * sb >= db) begin
                        m_ph = 2; m_beat = 0;
                     end else m_beat++;
                  end
               end
            2: if (bus_ready) begin
                  if (bus_err) begin
                     m_done = 1; m_err = 1; m_ph = 4;
                  end else begin
                     for (int k = 0; k < db; k++) mem[12'(m_dar + 32'(k))] = m_buf[k];
                     if (m_ctrl[1]) m_dar = m_dar + 32'(db);
                     m_cnt = (m_cnt > db) ? m_cnt - db : 0;
                     if (m_cnt == 0) begin
                        m_done = 1; m_ph = 4;
                     end else if (bwc != 0 && (m_cnt % (1 << (bwc + 1))) == 0) m_ph = 3;
                     else m_ph = 1;
                  end
               end
            3: m_ph = 1;
            default: ;
         endcase
      end
      if (cfg_we) begin
         case (cfg_sel)
            3'd0: m_sar  = cfg_wdata;
            3'd1: m_dar  = cfg_wdata;
            3'd2: m_cnt  = int'(cfg_wdata[CW-1:0]);
            3'd3: m_ctrl = cfg_wdata[8:0];
            default: ;
         endcase
      end
   endtask

   task automatic compare();
      bit ev;
      ev = (m_ph == 1 || m_ph == 2);
      chk(bus_valid === ev, "R2", "bus_valid", 32'(bus_valid), 32'(ev));
      chk(bus_req === ev, "R7", "bus_req", 32'(bus_req), 32'(ev));
      chk(chan_stat === exp_stat(), "R6", "chan_stat", 32'(chan_stat), 32'(exp_stat()));
      if (ev && bus_valid === 1'b1) begin
         if (m_ph == 1) begin
            chk(bus_addr === m_sar, "R3", "read addr", bus_addr, m_sar);
            chk(bus_wr === 1'b0, "R3", "read dir", 32'(bus_wr), 0);
            chk(bus_size === m_ctrl[3:2], "R3", "read size", 32'(bus_size), 32'(m_ctrl[3:2]));
         end else begin
            chk(bus_addr === m_dar, "R5", "write addr", bus_addr, m_dar);
            chk(bus_wr === 1'b1, "R5", "write dir", 32'(bus_wr), 1);
            chk(bus_size === m_ctrl[5:4], "R5", "write size", 32'(bus_size), 32'(m_ctrl[5:4]));
            for (int k = 0; k < sz(m_ctrl[5:4]); k++)
               chk(bus_wdata[k*8 +: 8] === m_buf[k], "R4", "write lane",
                   32'(bus_wdata[k*8 +: 8]), 32'(m_buf[k]));
         end
      end
      if (chan_stat[1] === 1'b1 && bus_req === 1'b0) rel_seen++;
   endtask

   task automatic cycle();
      slave_drive();
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] val);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
      cycle();
      cfg_we = 1'b0; cfg_sel = 3'd0; cfg_wdata = '0;
   endtask

   task automatic setup(input logic [31:0] src, input logic [31:0] dst,
                        input int cnt, input logic [8:0] ctrl, input int waits, input int err_at);
      wr(3'd0, src); wr(3'd1, dst); wr(3'd2, 32'(cnt)); wr(3'd3, 32'(ctrl));
      s_wait = waits; s_wcnt = 0; s_idx = 0; s_err_at = err_at; rel_seen = 0;
   endtask

   task automatic start();
      xfer_req = 1'b1;
      cycle();
      xfer_req = 1'b0;
   endtask

   task automatic run();
      for (int i = 0; i < 3000 && m_ph != 4 && m_ph != 0; i++) cycle();
      cycle();
   endtask

   task automatic clear();
      wr(3'd4, 32'h4);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL R6 watchdog act=hung exp=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] ref_b [16];
      for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
      rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0; xfer_req = 1'b0;
      bus_ready = 1'b0; bus_err = 1'b0; bus_rdata = '0;
      m_ph = 0; m_sar = '0; m_dar = '0; m_cnt = 0; m_ctrl = '0; m_beat = 0;
      m_reqst = 0; m_done = 0; m_err = 0;
      for (int k = 0; k < 4; k++) m_buf[k] = '0;
      s_wait = 0; s_wcnt = 0; s_idx = 0; s_err_at = -1; rel_seen = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(chan_stat === 4'b0000, "R1", "reset stat", 32'(chan_stat), 0);
      chk(bus_valid === 1'b0 && bus_req === 1'b0, "R1", "reset bus", 32'({bus_valid, bus_req}), 0);

      // R3 R5 R6: byte to byte copy, both incrementing
      setup(32'h100, 32'h200, 4, 9'h003, 0, -1);
      start(); run();
      for (int i = 0; i < 4; i++)
         chk(mem[12'h200 + 12'(i)] === mem[12'h100 + 12'(i)], "R5", "copy byte",
             32'(mem[12'h200 + 12'(i)]), 32'(mem[12'h100 + 12'(i)]));
      chk(chan_stat === 4'b0101, "R6", "done after copy", 32'(chan_stat), 32'h5);
      clear();

      // R4: bytes packed into words, with wait states
      setup(32'h140, 32'h300, 8, 9'h023, 1, -1);
      start(); run();
      for (int i = 0; i < 8; i++)
         chk(mem[12'h300 + 12'(i)] === mem[12'h140 + 12'(i)], "R4", "packed byte",
             32'(mem[12'h300 + 12'(i)]), 32'(mem[12'h140 + 12'(i)]));
      clear();

      // R3 R4: fixed halfword source into incrementing words
      ref_b[0] = mem[12'h400]; ref_b[1] = mem[12'h401];
      setup(32'h400, 32'h700, 8, 9'h026, 2, -1);
      start(); run();
      for (int i = 0; i < 8; i++)
         chk(mem[12'h700 + 12'(i)] === ref_b[i % 2], "R4", "fixed source lane",
             32'(mem[12'h700 + 12'(i)]), 32'(ref_b[i % 2]));
      clear();

      // R7: release every 4 bytes, one gap cycle in an 8-byte block
      setup(32'h180, 32'h800, 8, 9'h043, 0, -1);
      start(); run();
      chk(rel_seen == 1, "R7", "release cycles", 32'(rel_seen), 1);
      clear();
      // R7: code 000 never releases
      setup(32'h180, 32'h840, 8, 9'h003, 0, -1);
      start(); run();
      chk(rel_seen == 0, "R7", "no release", 32'(rel_seen), 0);
      clear();

      // R8: error on the third read of a packed transfer
      for (int i = 0; i < 8; i++) mem[12'h900 + 12'(i)] = 8'hEE;
      setup(32'h1C0, 32'h900, 8, 9'h023, 0, 2);
      start(); run();
      chk(chan_stat === 4'b1101, "R8", "read error stat", 32'(chan_stat), 32'hD);
      chk(mem[12'h900] === 8'hEE, "R8", "no write after read error", 32'(mem[12'h900]), 32'hEE);
      // R9: request while done is ignored
      start(); cycle(); cycle();
      chk(bus_valid === 1'b0 && chan_stat === 4'b1101, "R9", "request while done",
          32'({bus_valid, chan_stat}), 32'h0D);
      clear();
      chk(chan_stat === 4'b0000, "R9", "clear stat", 32'(chan_stat), 0);

      // R8: error on the first write
      for (int i = 0; i < 4; i++) mem[12'hA00 + 12'(i)] = 8'hEE;
      setup(32'h200, 32'hA00, 4, 9'h003, 1, 1);
      start(); run();
      chk(chan_stat === 4'b1101, "R8", "write error stat", 32'(chan_stat), 32'hD);
      chk(mem[12'hA00] === 8'hEE, "R8", "failed write kept", 32'(mem[12'hA00]), 32'hEE);
      clear();

      // R2: source wider than destination is ignored
      setup(32'h200, 32'hB00, 4, 9'h008, 0, -1);
      start(); cycle();
      chk(chan_stat === 4'b0000 && bus_valid === 1'b0, "R2", "bad size ratio",
          32'({bus_valid, chan_stat}), 0);
      // R2: invalid size code 11 is ignored
      wr(3'd3, 32'h03F);
      start(); cycle();
      chk(chan_stat === 4'b0000 && bus_valid === 1'b0, "R2", "invalid code",
          32'({bus_valid, chan_stat}), 0);
      // R2: zero count is ignored
      setup(32'h200, 32'hB00, 0, 9'h003, 0, -1);
      start(); cycle();
      chk(chan_stat === 4'b0000 && bus_valid === 1'b0, "R2", "zero count",
          32'({bus_valid, chan_stat}), 0);

      // R10: destination rewritten during the first read
      mem[12'hC00] = 8'hEE; mem[12'hD00] = 8'h00;
      setup(32'h260, 32'hC00, 4, 9'h003, 0, -1);
      start();
      wr(3'd1, 32'hD00);
      run();
      chk(mem[12'hC00] === 8'hEE, "R10", "old destination untouched", 32'(mem[12'hC00]), 32'hEE);
      chk(mem[12'hD00] === mem[12'h260], "R10", "new destination used",
          32'(mem[12'hD00]), 32'(mem[12'h260]));
      clear();

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule